// File: doc/BRIEF.md
# Watch-Crystal Divider Chain to a 10 Hz Tick

This block turns a 32.768 kHz timekeeping clock into a 10 Hz setting tick in three stages. The first stage is a pulse-swallowing counter. It suppresses one clock-enable out of every sixteen, which leaves 30720 enables per second. The second stage is a 9-bit binary counter that advances on those enables and emits a 60 Hz carry. The third stage is a 3-bit Johnson counter that advances on each carry. On the sixth carry it releases the tick. The tick is the carry gated with the current input clock cycle, so it lasts exactly one input cycle.

A clock-stop control holds the whole chain at its starting point. Timekeeping then restarts from a known phase when the control is cleared. The enable of the first stage and the 60 Hz carry are also brought out, so that a neighbour block can use the intermediate rates.

Top module: `wcd_chain`

## Requirements
- R1: Counting the first clock cycle after `stop` falls as cycle 0, `rate_en` is low in exactly the cycles whose index modulo 16 equals 15, and high in every other cycle while running.
- R2: Two consecutive cycles never both lack `rate_en`, so every 16-cycle group holds exactly 15 enables.
- R3: `mid_pulse` is high in the cycle that carries the 512th, 1024th, and so on (every 512th) `rate_en` enable. The first two fall in cycles 545 and 1091.
- R4: `tick` is high only in a cycle where `mid_pulse` is also high, and only on every sixth `mid_pulse`. The first tick falls in cycle 3275.
- R5: The Johnson stage only visits its six legal states. An illegal state is replaced by the all-zero state on the next clock.
- R6: `tick` is never high in two consecutive cycles.
- R7: The 32768 cycles that start at a release of `stop` hold exactly 30720 `rate_en` cycles, 60 `mid_pulse` cycles and 10 `tick` cycles.
- R8: `stop` is sampled synchronously. While it is high, `rate_en`, `mid_pulse` and `tick` are low and every stage is held at its start state. After it falls, timing restarts exactly as in R1, R3 and R4.
- R9: `rst_n` low resets the chain asynchronously to the same start state as `stop`. After reset, with `stop` low, timing begins at cycle 0 on the first clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop | input | 1 | Synchronous clock-stop hold, active high |
| rate_en | output | 1 | First-stage enable, 15 of every 16 cycles |
| mid_pulse | output | 1 | 60 Hz carry, one cycle wide |
| tick | output | 1 | 10 Hz setting pulse, one cycle wide |

## Verification
The chain is started from a stop release and from a reset release. Both starts must put the dropped enables, the 60 Hz carries and the ticks at the same computed cycle indices. A cycle-indexed vector table checks the edges either side of the first swallowed cycle and the first two carries. It also checks the cycles either side of the first tick, which separates an off-by-one in any stage from a wrong modulus. A full one-second window checks that the per-second counts of the three rates come out exactly. A stop asserted in mid-run checks that all outputs go quiet and that the phase restarts rather than resumes.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  localparam int JC_MAX = 8;

  // A Johnson word is legal when its bits hold at most one boundary
  // between a run of ones and a run of zeros.
  function automatic logic jc_legal(input logic [JC_MAX-1:0] q, input int n);
    int edges;
    edges = 0;
    for (int i = 0; i < n - 1; i++) begin
      if (q[i] != q[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

  // Next Johnson word: shift left, feed back the inverted top bit.
  // An illegal word goes to zero.
  function automatic logic [JC_MAX-1:0] jc_advance(input logic [JC_MAX-1:0] q, input int n);
    logic [JC_MAX-1:0] r;
    logic [JC_MAX-1:0] mask;
    mask = (JC_MAX'(1) << n) - JC_MAX'(1);
    if (!jc_legal(q, n)) begin
      r = '0;
    end else begin
      r = (q << 1) & mask;
      r[0] = ~q[n-1];
    end
    return r;
  endfunction

  // Last word before the wrap: only the top bit set.
  function automatic logic [JC_MAX-1:0] jc_final(input int n);
    return JC_MAX'(1) << (n - 1);
  endfunction

  // Number of enables that survive within one swallow group.
  function automatic int kept_per_group(input int period);
    return period - 1;
  endfunction

endpackage

// File: rtl/wcd_swallow.sv
module wcd_swallow #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic en_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;
  logic          drop_w;

  assign drop_w = (phase_q == LAST);
  assign en_o   = !hold && !drop_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (hold) begin
      phase_q <= '0;
    end else if (drop_w) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + CW'(1);
    end
  end

  AST_NO_DOUBLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !en_o) |=> (en_o || hold)); // R2

  AST_DROP_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> en_o); // R1

endmodule

// File: rtl/wcd_binary.sv
module wcd_binary #(
  parameter int STAGES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic step,
  output logic carry_o
);
  logic [STAGES-1:0] cnt_q;
  logic              full_w;

  assign full_w  = &cnt_q;
  assign carry_o = step && full_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + STAGES'(1);
    end
  end

  AST_CARRY_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> step); // R3

  AST_CARRY_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o); // R3

endmodule

// File: rtl/wcd_johnson.sv
module wcd_johnson
  import wcd_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic step,
  output logic wrap_o
);
  logic [STAGES-1:0] ring_q;
  logic [JC_MAX-1:0] ring_wide;
  logic [JC_MAX-1:0] next_wide;
  logic [JC_MAX-1:0] final_wide;
  logic              legal_w;
  logic              at_final_w;

  assign ring_wide  = JC_MAX'(ring_q);
  assign next_wide  = jc_advance(ring_wide, STAGES);
  assign final_wide = jc_final(STAGES);
  assign legal_w    = jc_legal(ring_wide, STAGES);
  assign at_final_w = (ring_wide == final_wide);
  assign wrap_o     = step && at_final_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
    end else if (hold) begin
      ring_q <= '0;
    end else if (!legal_w) begin
      ring_q <= '0;
    end else if (step) begin
      ring_q <= next_wide[STAGES-1:0];
    end
  end

  AST_RING_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    legal_w); // R5

  AST_RING_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_w |=> (ring_q == '0)); // R5

  AST_RING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !hold && legal_w) |=> $stable(ring_q)); // R4

endmodule

// File: rtl/wcd_chain.sv
module wcd_chain #(
  parameter int SWALLOW_PERIOD = 16,
  parameter int BIN_STAGES     = 9,
  parameter int RING_STAGES    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  output logic rate_en,
  output logic mid_pulse,
  output logic tick
);
  logic en_w;
  logic carry_w;
  logic wrap_w;

  wcd_swallow #(.PERIOD(SWALLOW_PERIOD)) u_swallow (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (stop),
    .en_o (en_w)
  );

  wcd_binary #(.STAGES(BIN_STAGES)) u_binary (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (stop),
    .step   (en_w),
    .carry_o(carry_w)
  );

  wcd_johnson #(.STAGES(RING_STAGES)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stop),
    .step  (carry_w),
    .wrap_o(wrap_w)
  );

  assign rate_en   = en_w;
  assign mid_pulse = carry_w;
  assign tick      = wrap_w;

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6

  AST_TICK_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> mid_pulse); // R4

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (!tick && !mid_pulse && !rate_en)); // R8

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop) |-> !mid_pulse); // R8

endmodule

// File: tb/wcd_chain_test.sv
module wcd_chain_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b1;
  logic rate_en, mid_pulse, tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wcd_chain uut (
    .clk(clk), .rst_n(rst_n), .stop(stop),
    .rate_en(rate_en), .mid_pulse(mid_pulse), .tick(tick)
  );

  // {cycle index after release, rate_en, mid_pulse, tick}
  localparam int NV = 11;
  localparam int VEC [NV][4] = '{
    '{0,    1, 0, 0},
    '{14,   1, 0, 0},
    '{15,   0, 0, 0},
    '{16,   1, 0, 0},
    '{544,  1, 0, 0},
    '{545,  1, 1, 0},
    '{546,  1, 0, 0},
    '{1091, 1, 1, 0},
    '{3274, 1, 0, 0},
    '{3275, 1, 1, 1},
    '{3276, 1, 0, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic release_stop();
    @(negedge clk);
    stop = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int v;
    int n1, n2, nt, first;
    int prev_tick;
    // R9: reset state
    #5;
    check("R9 reset rate_en", rate_en, 0);
    check("R9 reset tick", tick, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: stop held
    repeat (4) next_cycle();
    check("R8 stop rate_en", rate_en, 0);
    check("R8 stop mid_pulse", mid_pulse, 0);

    // Vector table walk: R1 R3 R4
    release_stop();
    v = 0;
    for (int k = 0; k <= 3276; k++) begin
      if (k > 0) next_cycle();
      if (v < NV && VEC[v][0] == k) begin
        check($sformatf("R1 rate_en @%0d", k), rate_en, VEC[v][1]);
        check($sformatf("R3 mid_pulse @%0d", k), mid_pulse, VEC[v][2]);
        check($sformatf("R4 tick @%0d", k), tick, VEC[v][3]);
        v++;
      end
    end

    // R8: stop in mid-run, then a full one-second window: R7 R2 R6 R4 R5
    @(negedge clk);
    stop = 1'b1;
    for (int k = 0; k < 20; k++) begin
      next_cycle();
      if (rate_en || mid_pulse || tick) begin
        errors++;
        $display("FAIL R8 outputs during stop actual %0d expected 0",
                 {rate_en, mid_pulse, tick});
      end
    end
    checks++;
    release_stop();
    n1 = 0; n2 = 0; nt = 0; first = -1; prev_tick = 0;
    for (int k = 0; k < 32768; k++) begin
      if (k > 0) next_cycle();
      n1 += rate_en;
      n2 += mid_pulse;
      nt += tick;
      if (tick && first < 0) first = k;
      if (tick && prev_tick) check("R6 tick width", 2, 1);
      if (tick && !mid_pulse) check("R4 tick without carry", 0, 1);
      if ((k % 16 == 15) && rate_en) check("R2 drop position", 1, 0);
      prev_tick = tick;
    end
    check("R7 rate_en per second", n1, 30720);
    check("R7 mid_pulse per second", n2, 60);
    check("R7 ticks per second (R5 six-state ring)", nt, 10);
    check("R8 first tick after restart", first, 3275);

    // R9: asynchronous reset in mid-run
    #3;
    rst_n = 1'b0;
    #2;
    check("R9 reset clears rate_en", rate_en, 1);
    check("R9 reset clears mid_pulse", mid_pulse, 0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    first = -1;
    for (int k = 0; k < 600; k++) begin
      if (k > 0) next_cycle();
      if (mid_pulse && first < 0) first = k;
    end
    check("R9 first carry after reset", first, 545);

    finish_run();
  end
endmodule